// File: doc/BRIEF.md
# Scatter-Gather Descriptor Fetch Unit with Error Halting

This block is the front end of a scatter-gather DMA channel. Software loads the address of a descriptor, sets the run bit, and the unit reads that descriptor from memory as eight 32-bit words. It uses a read port that has a single request in flight at a time. A good fetch delivers the buffer address, the next-descriptor pointer, the control word and the status word on a one-cycle descriptor-valid strobe. It then loads the next pointer into the current-descriptor register and parks the channel in the idle state. The next fetch starts when software sets run again.

If any word comes back with a non-OK response, the fetch is abandoned at once. The channel clears its run bit and enters the halted state. It records whether the response was a decode error or some other error, and it raises an error interrupt. The failed descriptor is never handed on. A small register file gives software the control word, the status word and the 64-bit current-descriptor pointer. A level interrupt output combines the status interrupt bits with their enables.

Top module: `dfu_top`

## Requirements
- R1: After reset the control register (address 0) reads 0x0000_0000, the status register (address 1) reads 0x0000_0001 (only halted, bit 0, set), irq is low and no read request is issued.
- R2: Setting the run bit (control bit 0) while halted clears halted. The unit then issues exactly eight read requests, to current-descriptor + 0, 4, 8 … 28 in that order. A new request is issued only after the response to the previous one.
- R3: Words are assembled little-endian: word 0/1 are the low/high halves of the buffer address, word 2/3 the low/high halves of the next pointer, words 4 and 5 are ignored, word 6 is the control word and word 7 the status word. A good fetch pulses desc_valid once with these values, loads the next pointer into the current-descriptor register, and sets idle (status bit 1) and the completion interrupt bit (status bit 12).
- R4: The first response with a code other than 2'b00 ends the fetch. No further read is issued, desc_valid does not pulse, the current-descriptor register keeps its value, the run bit clears and halted sets.
- R5: Response code 2'b11 (decode error) sets status bit 6. Codes 2'b10 and 2'b01 set status bit 5 (slave error). Every failed fetch also sets the error interrupt bit, status bit 14.
- R6: Status bits 5, 6, 12, 13 and 14 are sticky and are cleared only by writing 1 to them. Writing 0 to them has no effect.
- R7: irq is high exactly when some status bit in 12..14 is set together with the matching enable bit in control bits 12..14.
- R8: While a fetch is in progress, a control write updates the enable bits but not the run bit. Writes to the current-descriptor register (address 2 low half, address 3 high half) take effect only while halted.
- R9: While idle, writing the control register with run = 1 starts a fetch from the updated current-descriptor register. Writing it with run = 0 halts the channel (halted = 1, idle = 0).
- R10: Register map: address 0 control, 1 status, 2 current-descriptor low, 3 current-descriptor high. Unassigned bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational on csr_addr) |
| rd_req | output | 1 | One-cycle read request for a descriptor word |
| rd_addr | output | 64 | Byte address of the requested word |
| rsp_valid | input | 1 | Read response strobe |
| rsp_code | input | 2 | Response class: 00 OK, 01/10 slave error, 11 decode error |
| rsp_data | input | 32 | Read response data |
| desc_valid | output | 1 | One-cycle strobe: a complete descriptor is available |
| desc_buf_addr | output | 64 | Fetched buffer address |
| desc_next | output | 64 | Fetched next-descriptor pointer |
| desc_ctrl | output | 32 | Fetched control word |
| desc_stat | output | 32 | Fetched status word |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume that the memory side never returns a response unless one is owed. That means rsp_valid is high only while the unit waits for the answer to its single outstanding request, and only for one cycle per request. The bench memory model keeps to this. It answers each request once, after a delay of one to three cycles that varies from word to word, and it never drives rsp_valid at any other time. The register stimulus does not write the status register in the same cycle that a fetch ends. The bench waits on the halted or idle status bit before it touches that register.

// File: rtl/dfu_pkg.sv
package dfu_pkg;

    localparam int PTR_W       = 64;
    localparam int WORD_W      = 32;
    localparam int DESC_WORDS  = 8;
    localparam int IDX_W       = $clog2(DESC_WORDS);
    localparam int REG_ADDR_W  = 2;

    // register select codes
    localparam logic [REG_ADDR_W-1:0] RA_CTRL = 2'd0;
    localparam logic [REG_ADDR_W-1:0] RA_STAT = 2'd1;
    localparam logic [REG_ADDR_W-1:0] RA_CDLO = 2'd2;
    localparam logic [REG_ADDR_W-1:0] RA_CDHI = 2'd3;

    // bit positions
    localparam int B_RUN   = 0;
    localparam int B_HALT  = 0;
    localparam int B_IDLE  = 1;
    localparam int B_SLV   = 5;
    localparam int B_DEC   = 6;
    localparam int B_IRQLO = 12;
    localparam int N_IRQ   = 3;

    typedef enum logic [1:0] {
        RSP_OK   = 2'b00,
        RSP_RSVD = 2'b01,
        RSP_SLV  = 2'b10,
        RSP_DEC  = 2'b11
    } rsp_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_REQ,
        FS_WAIT
    } fstate_e;

    typedef struct packed {
        logic [PTR_W-1:0]  buf_addr;
        logic [PTR_W-1:0]  next_ptr;
        logic [WORD_W-1:0] ctrl_word;
        logic [WORD_W-1:0] stat_word;
    } desc_t;

    function automatic logic rsp_is_decode(input rsp_e c);
        return c == RSP_DEC;
    endfunction

endpackage

// File: rtl/dfu_fetch.sv
module dfu_fetch
    import dfu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PTR_W-1:0]  base,
    output logic              rd_req,
    output logic [PTR_W-1:0]  rd_addr,
    input  logic              rsp_valid,
    input  rsp_e              rsp_code,
    input  logic [WORD_W-1:0] rsp_data,
    output logic              busy,
    output logic              ok_pulse,
    output logic              err_pulse,
    output logic              err_dec,
    output desc_t             desc
);

    fstate_e          state;
    logic [IDX_W-1:0] idx;
    logic [PTR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= FS_IDLE;
            idx       <= '0;
            base_q    <= '0;
            ok_pulse  <= 1'b0;
            err_pulse <= 1'b0;
            err_dec   <= 1'b0;
            desc      <= '0;
        end else begin
            ok_pulse  <= 1'b0;
            err_pulse <= 1'b0;
            case (state)
                FS_IDLE: if (start) begin
                    base_q <= base;
                    idx    <= '0;
                    state  <= FS_REQ;
                end
                FS_REQ: state <= FS_WAIT;
                FS_WAIT: if (rsp_valid) begin
                    if (rsp_code != RSP_OK) begin
                        err_pulse <= 1'b1;
                        err_dec   <= rsp_is_decode(rsp_code);
                        state     <= FS_IDLE;
                    end else begin
                        case (idx)
                            3'd0: desc.buf_addr[31:0]  <= rsp_data;
                            3'd1: desc.buf_addr[63:32] <= rsp_data;
                            3'd2: desc.next_ptr[31:0]  <= rsp_data;
                            3'd3: desc.next_ptr[63:32] <= rsp_data;
                            3'd6: desc.ctrl_word       <= rsp_data;
                            3'd7: desc.stat_word       <= rsp_data;
                            default: ;
                        endcase
                        if (idx == IDX_W'(DESC_WORDS - 1)) begin
                            ok_pulse <= 1'b1;
                            state    <= FS_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= FS_REQ;
                        end
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    assign rd_req  = (state == FS_REQ);
    assign rd_addr = base_q + {{(PTR_W-IDX_W-2){1'b0}}, idx, 2'b00};
    assign busy    = (state != FS_IDLE);

    // R2
    single_req_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);
    // R2
    aligned_req_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> rd_addr[1:0] == 2'b00);
    // R2: responses only arrive while one is owed
    rsp_owed_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> state == FS_WAIT);
    // R4
    end_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(ok_pulse && err_pulse));
    // R4
    no_req_after_err_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> !rd_req);

endmodule

// File: rtl/dfu_regs.sv
module dfu_regs
    import dfu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0]     wdata,
    output logic [WORD_W-1:0]     rdata,
    input  logic                  busy,
    input  logic                  fetch_ok,
    input  logic                  fetch_err,
    input  logic                  fetch_dec,
    input  logic [PTR_W-1:0]      next_ptr,
    output logic                  start,
    output logic [PTR_W-1:0]      cur_desc,
    output logic                  irq
);

    logic             run;
    logic [N_IRQ-1:0] ien;
    logic [N_IRQ-1:0] ipend;
    logic             halted, idle, slv_err, dec_err;
    logic             wr_ctrl, wr_stat;
    logic [WORD_W-1:0] ctrl_word, stat_word;
    logic             unused_bits;

    assign wr_ctrl = we && addr == RA_CTRL;
    assign wr_stat = we && addr == RA_STAT;
    assign start   = wr_ctrl && wdata[B_RUN] && !busy && (halted || idle);
    assign unused_bits = ^{wdata[31:15], wdata[11:7], wdata[4:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            ien      <= '0;
            ipend    <= '0;
            halted   <= 1'b1;
            idle     <= 1'b0;
            slv_err  <= 1'b0;
            dec_err  <= 1'b0;
            cur_desc <= '0;
        end else begin
            if (wr_ctrl) begin
                ien <= wdata[B_IRQLO +: N_IRQ];
                if (!busy) begin
                    if (wdata[B_RUN] && (halted || idle)) begin
                        run    <= 1'b1;
                        halted <= 1'b0;
                        idle   <= 1'b0;
                    end else if (!wdata[B_RUN] && run) begin
                        run    <= 1'b0;
                        halted <= 1'b1;
                        idle   <= 1'b0;
                    end
                end
            end
            if (wr_stat) begin
                slv_err <= slv_err & ~wdata[B_SLV];
                dec_err <= dec_err & ~wdata[B_DEC];
                ipend   <= ipend & ~wdata[B_IRQLO +: N_IRQ];
            end
            if (we && halted && addr == RA_CDLO) cur_desc[31:0]  <= wdata;
            if (we && halted && addr == RA_CDHI) cur_desc[63:32] <= wdata;
            if (fetch_ok) begin
                idle     <= 1'b1;
                ipend[0] <= 1'b1;
                cur_desc <= next_ptr;
            end
            if (fetch_err) begin
                run      <= 1'b0;
                halted   <= 1'b1;
                idle     <= 1'b0;
                ipend[2] <= 1'b1;
                if (fetch_dec) dec_err <= 1'b1;
                else           slv_err <= 1'b1;
            end
        end
    end

    assign ctrl_word = {17'b0, ien, 11'b0, run};
    assign stat_word = {17'b0, ipend, 5'b0, dec_err, slv_err, 3'b0, idle, halted};

    always_comb begin
        case (addr)
            RA_CTRL: rdata = ctrl_word;
            RA_STAT: rdata = stat_word;
            RA_CDLO: rdata = cur_desc[31:0];
            default: rdata = cur_desc[63:32];
        endcase
    end

    assign irq = |(ipend & ien);

    // R4
    halt_on_err_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_err |=> !run && halted && ipend[2]);
    // R3
    idle_on_ok_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_ok |=> idle && ipend[0] && !halted);
    // R9
    state_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(halted && idle));
    // R8
    run_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && busy && !fetch_err) |=> run == $past(run));
    // R8
    ptr_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && !fetch_ok) |=> cur_desc == $past(cur_desc));

endmodule

// File: rtl/dfu_top.sv
module dfu_top
    import dfu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  csr_we,
    input  logic [REG_ADDR_W-1:0] csr_addr,
    input  logic [WORD_W-1:0]     csr_wdata,
    output logic [WORD_W-1:0]     csr_rdata,
    output logic                  rd_req,
    output logic [PTR_W-1:0]      rd_addr,
    input  logic                  rsp_valid,
    input  logic [1:0]            rsp_code,
    input  logic [WORD_W-1:0]     rsp_data,
    output logic                  desc_valid,
    output logic [PTR_W-1:0]      desc_buf_addr,
    output logic [PTR_W-1:0]      desc_next,
    output logic [WORD_W-1:0]     desc_ctrl,
    output logic [WORD_W-1:0]     desc_stat,
    output logic                  irq
);

    logic             f_busy, f_ok, f_err, f_dec, start;
    logic [PTR_W-1:0] cur_desc;
    desc_t            desc;

    dfu_fetch u_fetch (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .base      (cur_desc),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rsp_valid (rsp_valid),
        .rsp_code  (rsp_e'(rsp_code)),
        .rsp_data  (rsp_data),
        .busy      (f_busy),
        .ok_pulse  (f_ok),
        .err_pulse (f_err),
        .err_dec   (f_dec),
        .desc      (desc)
    );

    dfu_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (csr_we),
        .addr      (csr_addr),
        .wdata     (csr_wdata),
        .rdata     (csr_rdata),
        .busy      (f_busy | f_ok | f_err),
        .fetch_ok  (f_ok),
        .fetch_err (f_err),
        .fetch_dec (f_dec),
        .next_ptr  (desc.next_ptr),
        .start     (start),
        .cur_desc  (cur_desc),
        .irq       (irq)
    );

    assign desc_valid    = f_ok;
    assign desc_buf_addr = desc.buf_addr;
    assign desc_next     = desc.next_ptr;
    assign desc_ctrl     = desc.ctrl_word;
    assign desc_stat     = desc.stat_word;

    // R4
    no_valid_on_err_chk: assert property (@(posedge clk) disable iff (rst)
        f_err |-> !desc_valid);

endmodule

// File: tb/dfu_top_tb.sv
module dfu_top_tb;
    import dfu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_addr = 2'd0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        rd_req;
    logic [63:0] rd_addr;
    logic        rsp_valid = 1'b0;
    logic [1:0]  rsp_code = 2'b00;
    logic [31:0] rsp_data = '0;
    logic        desc_valid;
    logic [63:0] desc_buf_addr, desc_next;
    logic [31:0] desc_ctrl, desc_stat;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done_flag = 0;

    int          n_reads = 0;
    int          fail_idx = -1;
    logic [1:0]  fail_code = 2'b00;
    logic [63:0] cur_base = '0;
    desc_t       exp_q[$];

    always #5 clk = ~clk;

    dfu_top u_dut (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .rd_req(rd_req),
        .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_data(rsp_data), .desc_valid(desc_valid),
        .desc_buf_addr(desc_buf_addr), .desc_next(desc_next),
        .desc_ctrl(desc_ctrl), .desc_stat(desc_stat), .irq(irq)
    );

    function automatic logic [31:0] mem_word(input logic [63:0] a);
        logic [31:0] t;
        case (a[4:2])
            3'd2:    return a[31:0] + 32'h38;
            3'd3:    return a[63:32];
            default: begin
                t = a[31:0] * 32'h9E37_79B1;
                return t ^ 32'h5A5A_0000;
            end
        endcase
    endfunction

    function automatic desc_t expect_desc(input logic [63:0] b);
        desc_t d;
        d.buf_addr  = {mem_word(b + 4), mem_word(b)};
        d.next_ptr  = {mem_word(b + 12), mem_word(b + 8)};
        d.ctrl_word = mem_word(b + 24);
        d.stat_word = mem_word(b + 28);
        return d;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 400; i++) begin
            csr_read(RA_STAT, s);
            if (s[1:0] != 2'b00) return;
        end
    endtask

    // memory responder: one answer per request, varying delay
    initial begin
        logic [63:0] a;
        int k;
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (rd_req) begin
                a = rd_addr;
                k = n_reads;
                n_reads++;
                // R2: sequential word addresses
                check("R2 addr", a, cur_base + 64'(4 * k));
                repeat (k % 3) @(negedge clk);
                @(negedge clk);
                rsp_valid = 1'b1;
                if (k == fail_idx) begin
                    rsp_code = fail_code;
                    rsp_data = 32'hBAD0_BAD0;
                end else begin
                    rsp_code = 2'b00;
                    rsp_data = mem_word(a);
                end
            end
        end
    end

    // monitor: scoreboard compare of delivered descriptors
    initial begin
        desc_t e;
        forever begin
            @(negedge clk);
            if (!rst && desc_valid) begin
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R4 unexpected desc_valid actual=1 expected=0");
                end else begin
                    e = exp_q.pop_front();
                    check("R3 buf", desc_buf_addr, e.buf_addr);
                    check("R3 next", desc_next, e.next_ptr);
                    check("R3 ctrl", {32'b0, desc_ctrl}, {32'b0, e.ctrl_word});
                    check("R3 stat", {32'b0, desc_stat}, {32'b0, e.stat_word});
                end
            end
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic [63:0] A, B, C;
        A = 64'h0000_0001_0000_1000;
        B = A + 64'h40;
        C = A + 64'h80;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        csr_read(RA_CTRL, r); check("R1 ctrl", {32'b0, r}, 64'h0);
        csr_read(RA_STAT, r); check("R1 stat", {32'b0, r}, 64'h1);
        check("R1 irq", {63'b0, irq}, 64'h0);
        check("R1 rd_req", {63'b0, rd_req}, 64'h0);

        // R10 pointer access while halted
        csr_write(RA_CDLO, A[31:0]);
        csr_write(RA_CDHI, A[63:32]);
        csr_read(RA_CDLO, r); check("R10 cdlo", {32'b0, r}, {32'b0, A[31:0]});
        csr_read(RA_CDHI, r); check("R10 cdhi", {32'b0, r}, {32'b0, A[63:32]});

        // R2 R3 good fetch from halted
        cur_base = A; n_reads = 0; fail_idx = -1;
        exp_q.push_back(expect_desc(A));
        csr_write(RA_CTRL, 32'h0000_0001);
        wait_done();
        check("R2 reads", 64'(n_reads), 64'd8);
        csr_read(RA_STAT, r); check("R3 stat idle+cpl", {32'b0, r}, 64'h1002);
        csr_read(RA_CDLO, r); check("R3 cur ptr lo", {32'b0, r}, {32'b0, B[31:0]});
        csr_read(RA_CDHI, r); check("R3 cur ptr hi", {32'b0, r}, {32'b0, B[63:32]});

        // R9 halt from idle, R7 irq with enable
        csr_write(RA_CTRL, 32'h0000_1000);
        csr_read(RA_STAT, r); check("R9 halt", {32'b0, r}, 64'h1001);
        csr_read(RA_CTRL, r); check("R9 ctrl", {32'b0, r}, 64'h1000);
        check("R7 irq on", {63'b0, irq}, 64'h1);

        // R6 write 0 no effect, write 1 clears
        csr_write(RA_STAT, 32'h0000_0000);
        csr_read(RA_STAT, r); check("R6 w0", {32'b0, r}, 64'h1001);
        csr_write(RA_STAT, 32'h0000_1000);
        csr_read(RA_STAT, r); check("R6 w1c", {32'b0, r}, 64'h0001);
        check("R7 irq off", {63'b0, irq}, 64'h0);

        // R8 control write during fetch keeps run, updates enables
        cur_base = B; n_reads = 0;
        exp_q.push_back(expect_desc(B));
        csr_write(RA_CTRL, 32'h0000_7001);
        csr_write(RA_CTRL, 32'h0000_0000);
        csr_read(RA_CTRL, r); check("R8 ctrl busy", {32'b0, r}, 64'h0001);
        wait_done();
        check("R2 reads B", 64'(n_reads), 64'd8);
        csr_read(RA_STAT, r); check("R3 stat B", {32'b0, r}, 64'h1002);
        check("R7 irq masked", {63'b0, irq}, 64'h0);

        // R8 pointer write ignored when not halted
        csr_write(RA_CDLO, 32'hDEAD_0000);
        csr_read(RA_CDLO, r); check("R8 ptr locked", {32'b0, r}, {32'b0, C[31:0]});

        // R9 kick from idle; R4 R5 decode error at word 3
        cur_base = C; n_reads = 0; fail_idx = 3; fail_code = 2'b11;
        csr_write(RA_CTRL, 32'h0000_7001);
        wait_done();
        repeat (4) @(negedge clk);
        check("R4 reads stop", 64'(n_reads), 64'd4);
        csr_read(RA_STAT, r); check("R5 decode", {32'b0, r}, 64'h5041);
        csr_read(RA_CTRL, r); check("R4 run cleared", {32'b0, r}, 64'h7000);
        csr_read(RA_CDLO, r); check("R4 ptr kept", {32'b0, r}, {32'b0, C[31:0]});
        check("R7 irq err", {63'b0, irq}, 64'h1);
        csr_write(RA_STAT, 32'h0000_7060);
        csr_read(RA_STAT, r); check("R6 clear errs", {32'b0, r}, 64'h0001);
        check("R7 irq cleared", {63'b0, irq}, 64'h0);

        // R5 slave error (code 10) on first word
        n_reads = 0; fail_idx = 0; fail_code = 2'b10;
        csr_write(RA_CTRL, 32'h0000_4001);
        wait_done();
        repeat (4) @(negedge clk);
        check("R4 reads one", 64'(n_reads), 64'd1);
        csr_read(RA_STAT, r); check("R5 slave", {32'b0, r}, 64'h4021);
        csr_write(RA_STAT, 32'h0000_4020);

        // R5 code 01 on last word counts as slave error
        n_reads = 0; fail_idx = 7; fail_code = 2'b01;
        csr_write(RA_CTRL, 32'h0000_0001);
        wait_done();
        check("R4 reads eight", 64'(n_reads), 64'd8);
        csr_read(RA_STAT, r); check("R5 code01", {32'b0, r}, 64'h4021);
        csr_write(RA_STAT, 32'h0000_4020);

        // R3 successful retry of the same descriptor
        n_reads = 0; fail_idx = -1;
        exp_q.push_back(expect_desc(C));
        csr_write(RA_CTRL, 32'h0000_0001);
        wait_done();
        csr_read(RA_STAT, r); check("R3 retry stat", {32'b0, r}, 64'h1002);
        csr_read(RA_CDLO, r); check("R3 retry ptr", {32'b0, r}, {32'b0, C[31:0] + 32'h40});
        repeat (3) @(negedge clk);
        check("R3 queue drained", 64'(exp_q.size()), 64'd0);

        finish_run();
    end

endmodule